// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 24-bit virtual address into a 32-bit physical address by walking a two-level page table in memory. There is no translation cache, so every request costs two table reads. The caller presents a virtual address, an access kind (read or write) and the base address of the top-level table. The walker fetches one entry from each level over a single-outstanding read port, which accepts a one-cycle request and returns one response after any number of cycles. It then reports the physical address, or a page fault, with a one-cycle completion strobe.

Pages are 4 KiB. The 12-bit page number is split into two 6-bit indices, one for each 64-entry table. Each table entry is 32 bits wide. The walker reads entries and never writes them. Allocation on fault and dirty tracking belong to other logic.

Top module: `xlate_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, and `memReqValid`, `donePulse` and `pageFault` are 0.
- R2: The first read goes to `rootBase + 4*vaddr[23:18]`, using the root base captured when the request was accepted.
- R3: An entry holds the next page number in bits 31:12 and flags in bits 11:0: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 dirty. The second read goes to `{firstEntry[31:12], 12'h000} + 4*vaddr[17:12]`.
- R4: A successful walk raises `donePulse` for exactly one cycle with `pageFault` 0, and `paddr` is `{leafEntry[31:12], vaddr[11:0]}`.
- R5: If the first-level entry has bit 0 clear, the walk ends in a fault and no second read is issued.
- R6: If the leaf entry has bit 0 clear, the walk ends in a fault.
- R7: A write whose leaf lacks bit 2, or a read whose leaf lacks bit 1, ends in a fault. A fault raises `donePulse` and `pageFault` together for one cycle, and `paddr` reads 0.
- R8: Requests are accepted only while `reqReady` is 1. A request raised during a walk is dropped and does not change that walk's result.
- R9: Each level issues exactly one read request, one cycle long, and the walker waits for the response however long it takes.
- R10: A response that arrives while no read is outstanding is ignored. It produces no completion and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translate request |
| reqVaddr | input | 24 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| rootBase | input | 32 | Byte address of the top-level table |
| reqReady | output | 1 | Walker idle and able to accept a request |
| memReqValid | output | 1 | One-cycle table read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 32 | Table entry returned by memory |
| donePulse | output | 1 | One-cycle completion strobe |
| pageFault | output | 1 | Completion is a fault (valid with donePulse) |
| paddr | output | 32 | Translated physical address |

## Verification
The hardest cases to reach from the ports are a stray response arriving while the walker is idle and a second request arriving in the middle of a walk. Both depend on when the inputs arrive relative to the walk, not on the table contents. The bench forces a response strobe onto the read port outside any walk and confirms that nothing completes and nothing is fetched. It then raises a new request while the first is waiting on a slow response and checks that only the first address is translated. The table contents are chosen so that each permission and validity combination falls on a distinct top-level index.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W     = 24;
  localparam int PA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 6;
  localparam int PTE_W    = 32;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int ENTRY_SH = 2;
  localparam int FLAG_V   = 0;
  localparam int FLAG_R   = 1;
  localparam int FLAG_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } walkState_e;

  typedef struct packed {
    logic capture;
    logic selLevel2;
    logic latchPte1;
    logic latchLeaf;
  } walkStrobe_t;
endpackage

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [PA_W-1:0]   rootBase,
  input  logic [PTE_W-1:0]  memRspData,
  output logic [PA_W-1:0]   memReqAddr,
  output logic              pteValid,
  output logic              permOk,
  output logic [PA_W-1:0]   paddr
);
  localparam int PAD_W = PA_W - IDX_W - ENTRY_SH;

  logic [VA_W-1:0]  vaddrQ;
  logic [PA_W-1:0]  rootQ;
  logic             writeQ;
  logic [PPN_W-1:0] pte1PpnQ;
  logic [PA_W-1:0]  paddrQ;
  logic [IDX_W-1:0] idxHi, idxLo;
  logic [PA_W-1:0]  offHi, offLo;
  logic             unusedPteBits;

  assign idxHi = vaddrQ[OFF_W+2*IDX_W-1:OFF_W+IDX_W];
  assign idxLo = vaddrQ[OFF_W+IDX_W-1:OFF_W];
  assign offHi = {{PAD_W{1'b0}}, idxHi, {ENTRY_SH{1'b0}}};
  assign offLo = {{PAD_W{1'b0}}, idxLo, {ENTRY_SH{1'b0}}};

  assign memReqAddr = strb.selLevel2 ? ({pte1PpnQ, {OFF_W{1'b0}}} + offLo)
                                     : (rootQ + offHi);

  assign pteValid = memRspData[FLAG_V];
  assign permOk   = writeQ ? memRspData[FLAG_W] : memRspData[FLAG_R];
  assign unusedPteBits = ^memRspData[OFF_W-1:FLAG_W+1];
  assign paddr    = paddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ   <= '0;
      rootQ    <= '0;
      writeQ   <= 1'b0;
      pte1PpnQ <= '0;
      paddrQ   <= '0;
    end else begin
      if (strb.capture) begin
        vaddrQ <= reqVaddr;
        rootQ  <= rootBase;
        writeQ <= reqWrite;
        paddrQ <= '0;
      end
      if (strb.latchPte1) pte1PpnQ <= memRspData[PTE_W-1:OFF_W];
      if (strb.latchLeaf) paddrQ   <= {memRspData[PTE_W-1:OFF_W], vaddrQ[OFF_W-1:0]};
    end
  end

  // R2: the captured address stays put for the whole walk
  a_r2_vaddr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(vaddrQ));
  // R4: the low bits of the result come from the page offset
  a_r4_offset: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchLeaf |=> paddrQ[OFF_W-1:0] == $past(vaddrQ[OFF_W-1:0]));
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        pteValid,
  input  logic        permOk,
  output walkStrobe_t strb,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        donePulse,
  output logic        pageFault
);
  walkState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strb        = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    donePulse   = 1'b0;
    pageFault   = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.capture = 1'b1;
          nextState    = ST_L1_REQ;
        end
      end
      ST_L1_REQ: begin
        memReqValid = 1'b1;
        nextState   = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (memRspValid) begin
          if (pteValid) begin
            strb.latchPte1 = 1'b1;
            nextState      = ST_L2_REQ;
          end else begin
            nextState = ST_FAULT;
          end
        end
      end
      ST_L2_REQ: begin
        memReqValid    = 1'b1;
        strb.selLevel2 = 1'b1;
        nextState      = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        strb.selLevel2 = 1'b1;
        if (memRspValid) begin
          if (pteValid && permOk) begin
            strb.latchLeaf = 1'b1;
            nextState      = ST_DONE;
          end else begin
            nextState = ST_FAULT;
          end
        end
      end
      ST_DONE: begin
        donePulse = 1'b1;
        nextState = ST_IDLE;
      end
      ST_FAULT: begin
        donePulse = 1'b1;
        pageFault = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R9: a read request lasts exactly one cycle
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R4: completion strobe lasts exactly one cycle
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R5: an invalid top-level entry leads straight to a fault
  a_r5_l1_fault: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_L1_WAIT && memRspValid && !pteValid) |=> (donePulse && pageFault));
  // R8: no completion while the walker advertises idle
  a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !donePulse && !memReqValid);
  // R10: a response seen while idle starts nothing
  a_r10_stray: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid && memRspValid) |=> reqReady);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [23:0]      reqVaddr,
  input  logic             reqWrite,
  input  logic [31:0]      rootBase,
  output logic             reqReady,
  output logic             memReqValid,
  output logic [31:0]      memReqAddr,
  input  logic             memRspValid,
  input  logic [31:0]      memRspData,
  output logic             donePulse,
  output logic             pageFault,
  output logic [31:0]      paddr
);
  walkStrobe_t strb;
  logic        pteValid;
  logic        permOk;

  xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .pteValid(pteValid), .permOk(permOk), .strb(strb), .reqReady(reqReady),
    .memReqValid(memReqValid), .donePulse(donePulse), .pageFault(pageFault)
  );

  xlate_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .rootBase(rootBase), .memRspData(memRspData),
    .memReqAddr(memReqAddr), .pteValid(pteValid), .permOk(permOk),
    .paddr(paddr)
  );

  // R7: a fault never carries an address
  a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    pageFault |-> donePulse && paddr == '0);
endmodule

// File: tb/sim_xlate_walker.sv
`timescale 1ns/1ps
module sim_xlate_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] rootBase = 32'h0004_0000;
  logic        reqReady, memReqValid, donePulse, pageFault;
  logic [31:0] memReqAddr, paddr;
  logic        memRspValid;
  logic [31:0] memRspData;

  logic        mdlValid = 1'b0;
  logic [31:0] mdlData = '0;
  logic        strayValid = 1'b0;
  logic [31:0] strayData = '0;
  logic        pend = 1'b0;
  logic [31:0] pendAddr = '0;
  int          cnt = 0;
  int          latency = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] reqLog [$];
  int          testCnt = 0;
  int          failCnt = 0;

  assign memRspValid = mdlValid | strayValid;
  assign memRspData  = strayValid ? strayData : mdlData;

  always #4 clk = ~clk;

  xlate_walker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .rootBase(rootBase), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .donePulse(donePulse), .pageFault(pageFault), .paddr(paddr)
  );

  always @(posedge clk) begin
    mdlValid <= 1'b0;
    if (memReqValid) begin
      reqLog.push_back(memReqAddr);
      pend     <= 1'b1;
      pendAddr <= memReqAddr;
      cnt      <= latency;
    end else if (pend) begin
      if (cnt == 0) begin
        mdlValid <= 1'b1;
        mdlData  <= mem.exists(pendAddr) ? mem[pendAddr] : 32'h0;
        pend     <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Build a mapping following the entry layout of R3
  task automatic mapPage(input logic [23:0] va, input logic [19:0] l2Ppn, input logic [11:0] l1Flags,
                         input logic [19:0] leafPpn, input logic [11:0] leafFlags);
    mem[rootBase + 32'(va[23:18]) * 4] = {l2Ppn, l1Flags};
    mem[{l2Ppn, 12'h000} + 32'(va[17:12]) * 4] = {leafPpn, leafFlags};
  endtask

  task automatic issue(input logic [23:0] va, input bit wr);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit seen, output logic flt, output logic [31:0] pa);
    seen = 1'b0; flt = 1'b0; pa = '0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (donePulse) begin seen = 1'b1; flt = pageFault; pa = paddr; end
      else @(negedge clk);
    end
  endtask

  task automatic walk(input logic [23:0] va, input bit wr, input bit expFault,
                      input logic [31:0] expPa, input string req);
    bit seen; logic flt; logic [31:0] pa;
    reqLog.delete();
    issue(va, wr);
    waitDone(seen, flt, pa);
    chk(seen, {req, " done"}, 32'(seen), 1);
    chk(flt == expFault, {req, " fault"}, 32'(flt), 32'(expFault));
    chk(pa == expPa, {req, " paddr"}, pa, expPa);
    @(negedge clk);
    chk(!donePulse, "R4 single-cycle done", 32'(donePulse), 0);
  endtask

  task automatic t_reset();
    chk(reqReady == 1'b1, "R1 ready", 32'(reqReady), 1);
    chk(!memReqValid && !donePulse && !pageFault, "R1 quiet",
        {29'b0, memReqValid, donePulse, pageFault}, 0);
  endtask

  task automatic t_basic();
    latency = 0;
    mapPage(24'h123456, 20'h00050, 12'h001, 20'hABCDE, 12'h007);
    walk(24'h123456, 1'b0, 1'b0, 32'hABCDE456, "R4 basic read");
    chk(reqLog.size() == 2, "R9 two reads", reqLog.size(), 2);
    if (reqLog.size() == 2) begin
      chk(reqLog[0] == 32'h0004_0010, "R2 first address", reqLog[0], 32'h0004_0010);
      chk(reqLog[1] == 32'h0005_008C, "R3 second address", reqLog[1], 32'h0005_008C);
    end
    walk(24'h123456, 1'b1, 1'b0, 32'hABCDE456, "R7 write permitted");
  endtask

  task automatic t_maxSlow();
    latency = 5;
    mapPage(24'hFFFFFF, 20'h00061, 12'h001, 20'hFFFFF, 12'h003);
    walk(24'hFFFFFF, 1'b0, 1'b0, 32'hFFFFFFFF, "R9 slow memory max address");
    if (reqLog.size() == 2) begin
      chk(reqLog[0] == 32'h0004_00FC, "R2 top index", reqLog[0], 32'h0004_00FC);
      chk(reqLog[1] == 32'h0006_10FC, "R3 top index", reqLog[1], 32'h0006_10FC);
    end else chk(1'b0, "R9 slow read count", reqLog.size(), 2);
    latency = 0;
  endtask

  task automatic t_perms();
    mapPage(24'h2A5000, 20'h00070, 12'h001, 20'h12345, 12'h003);
    walk(24'h2A5000, 1'b1, 1'b1, 32'h0, "R7 write denied");
    walk(24'h2A5000, 1'b0, 1'b0, 32'h12345000, "R7 read on read-only");
    mapPage(24'h301ABC, 20'h00071, 12'h001, 20'h0BEEF, 12'h005);
    walk(24'h301ABC, 1'b0, 1'b1, 32'h0, "R7 read denied");
    walk(24'h301ABC, 1'b1, 1'b0, 32'h0BEEFABC, "R7 write on write-only");
  endtask

  task automatic t_invalid();
    walk(24'h800000, 1'b0, 1'b1, 32'h0, "R5 l1 invalid");
    chk(reqLog.size() == 1, "R5 no second read", reqLog.size(), 1);
    mapPage(24'h0C3000, 20'h00080, 12'h001, 20'h55555, 12'h006);
    walk(24'h0C3000, 1'b0, 1'b1, 32'h0, "R6 leaf invalid");
    chk(reqLog.size() == 2, "R6 both reads", reqLog.size(), 2);
  endtask

  task automatic t_busy();
    bit seen; logic flt; logic [31:0] pa;
    latency = 4;
    reqLog.delete();
    issue(24'h123456, 1'b0);
    @(negedge clk);
    chk(reqReady == 1'b0, "R8 busy not ready", 32'(reqReady), 0);
    reqValid = 1'b1; reqVaddr = 24'h2A5000;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(seen, flt, pa);
    chk(seen && !flt && pa == 32'hABCDE456, "R8 dropped request", pa, 32'hABCDE456);
    repeat (10) @(negedge clk);
    chk(reqLog.size() == 2, "R8 no extra walk", reqLog.size(), 2);
    latency = 0;
  endtask

  task automatic t_stray();
    bit sawDone = 1'b0;
    reqLog.delete();
    @(negedge clk);
    strayValid = 1'b1; strayData = 32'hFFFFF00F;
    @(negedge clk);
    strayValid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (donePulse) sawDone = 1'b1;
      @(negedge clk);
    end
    chk(!sawDone, "R10 stray no done", 32'(sawDone), 0);
    chk(reqLog.size() == 0, "R10 stray no read", reqLog.size(), 0);
    walk(24'h123456, 1'b0, 1'b0, 32'hABCDE456, "R10 walk after stray");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_basic();
    t_maxSlow();
    t_perms();
    t_invalid();
    t_busy();
    t_stray();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule